// File: doc/BRIEF.md
# Multi-Pass Block RAM Fill Engine

This block fills a small window of a dual-port block RAM from the programmable-logic side, so that a processor can read the result through the other port. It sits idle after reset and starts only on request: the processor raises a start input, the engine streams one word per clock into a fixed run of word addresses, and it repeats that run several times. Each pass stores a different value range, so the value a reader finds tells which pass last reached that word.

When the last pass ends, the engine turns the RAM port off, clears every port output, and raises a ready flag. The flag stays up until the processor confirms that it has read the data. The engine then goes back to idle. It will not start again until the start input has been seen low and then high, so a start level left high does not loop the fill. It does not matter which side comes out of reset first.

With default parameters, each pass covers word indices 0 to 9, and three passes store 0–9, 10–19 and 20–29. The address output is a word index. A byte address is that index shifted left by two, outside the block.

Top module: `multipass_bram_writer`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, `bram_en`, `bram_we`, `bram_addr`, `bram_wdata` and `ram_full` are all zero on the following cycle.
- R2: After reset the engine does not start, even with `go` held high, until `go` has been sampled low at least once while idle.
- R3: A clock edge that samples `go` high while idle and armed produces, in the next cycle, the first write: `bram_en`=1, `bram_we`=4'b1111, `bram_addr`=0, `bram_wdata`=0.
- R4: Within a pass, one word is written per cycle at word indices 0 to WORDS-1 in ascending order. `bram_we` is 4'b1111 on every write cycle and 4'b0000 on every other cycle.
- R5: There are PASSES passes (default 3), and the written value equals pass×WORDS + index (default 0–9, 10–19, 20–29).
- R6: Between two passes there is exactly one cycle with `bram_en`=1, `bram_we`=0, `bram_addr`=0 and `bram_wdata`=0. `bram_en` stays high from the first write to the last.
- R7: The cycle after the last write, `bram_en`, `bram_we`, `bram_addr` and `bram_wdata` are zero and `ram_full` is 1. With defaults this is 32 cycles after the first write.
- R8: `ram_full` stays high while `ack` is low. An edge that samples `ack` high while full clears `ram_full` in the next cycle and returns the engine to idle.
- R9: After an acknowledge, a `go` still held high starts nothing. A new fill begins only after `go` has been sampled low and then high.
- R10: `go` and `ack` have no effect while writing is under way, and `ack` has no effect while idle.
- R11: `bram_rst` is high only during and one cycle after reset. It is low on every write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request from the processor |
| ack | input | 1 | Processor has read the data |
| bram_en | output | 1 | RAM port enable |
| bram_we | output | WE_W | Byte write enables |
| bram_addr | output | ADDR_W | Word index |
| bram_wdata | output | DATA_W | Write data |
| bram_rst | output | 1 | RAM port reset, active high |
| ram_full | output | 1 | Fill complete, data ready to read |

## Verification
The hardest case to reach from the ports is the re-arm rule. It is only visible when `go` is still high at the moment the acknowledge returns the engine to idle, and again when `go` stays high through reset. The bench holds `go` high across both events and watches `bram_en` for several cycles before it drops `go` for one cycle. It also toggles `go` and pulses `ack` during the fill, at the cycles a stimulus table lists, and compares every cycle of the fill against the pass and index formula.

// File: rtl/multipass_bram_writer.sv
module multipass_bram_writer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WE_W   = 4,
  parameter int WORDS  = 10,
  parameter int PASSES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              ack,
  output logic              bram_en,
  output logic [WE_W-1:0]   bram_we,
  output logic [ADDR_W-1:0] bram_addr,
  output logic [DATA_W-1:0] bram_wdata,
  output logic              bram_rst,
  output logic              ram_full
);
  localparam int IDX_W  = (WORDS  > 1) ? $clog2(WORDS)  : 1;
  localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(WORDS - 1);
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);
  localparam logic [WE_W-1:0]   WE_ALL    = '1;

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_GAP, S_FULL} state_t;

  state_t              state_q;
  logic                armed_q;
  logic [IDX_W-1:0]    idx_q;
  logic [PASS_W-1:0]   pass_q;
  logic [DATA_W-1:0]   next_val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      armed_q    <= 1'b0;
      idx_q      <= '0;
      pass_q     <= '0;
      next_val_q <= '0;
      bram_en    <= 1'b0;
      bram_we    <= '0;
      bram_addr  <= '0;
      bram_wdata <= '0;
      ram_full   <= 1'b0;
      bram_rst   <= 1'b1;
    end else begin
      bram_rst <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (!go) begin
            armed_q <= 1'b1;
          end else if (armed_q) begin
            state_q    <= S_WRITE;
            armed_q    <= 1'b0;
            idx_q      <= '0;
            pass_q     <= '0;
            next_val_q <= DATA_W'(1);
            bram_en    <= 1'b1;
            bram_we    <= WE_ALL;
            bram_addr  <= '0;
            bram_wdata <= '0;
          end
        end
        S_WRITE: begin
          if (idx_q == LAST_IDX) begin
            idx_q      <= '0;
            bram_addr  <= '0;
            bram_we    <= '0;
            bram_wdata <= '0;
            if (pass_q == LAST_PASS) begin
              state_q  <= S_FULL;
              bram_en  <= 1'b0;
              ram_full <= 1'b1;
            end else begin
              state_q <= S_GAP;
              pass_q  <= pass_q + PASS_W'(1);
            end
          end else begin
            idx_q      <= idx_q + IDX_W'(1);
            bram_addr  <= ADDR_W'(idx_q) + ADDR_W'(1);
            bram_wdata <= next_val_q;
            next_val_q <= next_val_q + DATA_W'(1);
          end
        end
        S_GAP: begin
          state_q    <= S_WRITE;
          bram_we    <= WE_ALL;
          bram_addr  <= '0;
          bram_wdata <= next_val_q;
          next_val_q <= next_val_q + DATA_W'(1);
        end
        S_FULL: begin
          if (ack) begin
            ram_full <= 1'b0;
            state_q  <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/multipass_bram_writer_chk.sv
module multipass_bram_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WE_W   = 4,
  parameter int WORDS  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              go,
  input logic              ack,
  input logic              bram_en,
  input logic [WE_W-1:0]   bram_we,
  input logic [ADDR_W-1:0] bram_addr,
  input logic [DATA_W-1:0] bram_wdata,
  input logic              bram_rst,
  input logic              ram_full
);
  localparam logic [WE_W-1:0] WE_ALL = '1;

  p_we_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (bram_we == '0) || (bram_we == WE_ALL));

  p_we_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    (bram_we != '0) |-> bram_en);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    ((bram_we != '0) && (bram_addr != '0)) |-> ($past(bram_addr) + ADDR_W'(1) == bram_addr));

  p_addr_range_r4: assert property (@(posedge clk) disable iff (rst)
    (bram_we != '0) |-> (bram_addr < ADDR_W'(WORDS)));

  p_data_match_r5: assert property (@(posedge clk) disable iff (rst)
    (bram_we != '0) |-> ((bram_wdata % DATA_W'(WORDS)) == DATA_W'(bram_addr)));

  p_first_write_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(bram_en) |-> ((bram_we == WE_ALL) && (bram_addr == '0) && (bram_wdata == '0)));

  p_full_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ram_full |-> (!bram_en && (bram_we == '0) && (bram_addr == '0) && (bram_wdata == '0)));

  p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ram_full && !ack) |=> ram_full);

  p_full_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (ram_full && ack) |=> !ram_full);

  p_memrst_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    bram_rst |-> (bram_we == '0));
endmodule

bind multipass_bram_writer multipass_bram_writer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_W(WE_W), .WORDS(WORDS)
) u_chk (
  .clk(clk), .rst(rst), .go(go), .ack(ack), .bram_en(bram_en),
  .bram_we(bram_we), .bram_addr(bram_addr), .bram_wdata(bram_wdata),
  .bram_rst(bram_rst), .ram_full(ram_full)
);

// File: tb/test_multipass_bram_writer.sv
module test_multipass_bram_writer;
  localparam int CLK_P  = 10;
  localparam int WORDS  = 10;
  localparam int PASSES = 3;
  localparam int SPAN   = PASSES * (WORDS + 1) - 1;

  typedef struct packed { logic [7:0] k; logic go_v; logic ack_v; } stim_t;
  localparam int NSTIM = 6;
  localparam stim_t STIM [NSTIM] = '{
    '{8'd3,  1'b1, 1'b1},
    '{8'd4,  1'b1, 1'b0},
    '{8'd5,  1'b0, 1'b0},
    '{8'd6,  1'b1, 1'b1},
    '{8'd10, 1'b1, 1'b1},
    '{8'd30, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, go = 1'b1, ack = 1'b0;
  logic bram_en, bram_rst, ram_full;
  logic [3:0]  bram_we;
  logic [31:0] bram_addr, bram_wdata;
  int total = 0, bad = 0;

  multipass_bram_writer i_multipass_bram_writer (
    .clk(clk), .rst(rst), .go(go), .ack(ack), .bram_en(bram_en),
    .bram_we(bram_we), .bram_addr(bram_addr), .bram_wdata(bram_wdata),
    .bram_rst(bram_rst), .ram_full(ram_full));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [69:0] pack_now();
    return {bram_en, bram_we, bram_addr, bram_wdata, ram_full};
  endfunction

  function automatic logic [69:0] exp_fill(int k);
    int p, pos;
    if (k == SPAN) return {1'b0, 4'h0, 32'd0, 32'd0, 1'b1};
    p = k / (WORDS + 1);
    pos = k % (WORDS + 1);
    if (pos == WORDS) return {1'b1, 4'h0, 32'd0, 32'd0, 1'b0};
    return {1'b1, 4'hF, 32'(pos), 32'(p * WORDS + pos), 1'b0};
  endfunction

  task automatic chk(string req, logic [69:0] act, logic [69:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  localparam logic [69:0] IDLE_V = '0;

  task automatic run_fill(string tag);
    go = 1'b1;
    for (int k = 0; k <= SPAN; k++) begin
      step();
      chk($sformatf("%s fill k=%0d R4 R5 R6 R7", tag, k), pack_now(), exp_fill(k));
      if (k == 0) chk("R3 first write", pack_now(), {1'b1, 4'hF, 32'd0, 32'd0, 1'b0});
      if (k < SPAN && bram_rst !== 1'b0) chk("R11 bram_rst low while writing", 70'(bram_rst), 70'd0);
      for (int s = 0; s < NSTIM; s++)
        if (int'(STIM[s].k) == k) begin go = STIM[s].go_v; ack = STIM[s].ack_v; end
    end
    ack = 1'b0;
    go = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    step(); step();
    chk("R1 reset outputs", pack_now(), IDLE_V);
    chk("R11 bram_rst during reset", 70'(bram_rst), 70'd1);
    rst = 1'b0;
    step();
    chk("R11 bram_rst after reset", 70'(bram_rst), 70'd0);
    ack = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R2 go held through reset R10 idle ack", pack_now(), IDLE_V);
    end
    ack = 1'b0;
    go = 1'b0;
    step();
    run_fill("first");
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R8 full holds", pack_now(), {1'b0, 4'h0, 32'd0, 32'd0, 1'b1});
      go = (i % 2 == 0) ? 1'b0 : 1'b1;
    end
    go = 1'b1;
    ack = 1'b1;
    step();
    chk("R8 ack clears full", pack_now(), IDLE_V);
    ack = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R9 go held after ack", pack_now(), IDLE_V);
    end
    go = 1'b0;
    step();
    chk("R9 idle with go low", pack_now(), IDLE_V);
    run_fill("second");
    ack = 1'b1;
    step();
    ack = 1'b0;
    go = 1'b0;
    step();
    go = 1'b1;
    for (int i = 0; i < 4; i++) step();
    rst = 1'b1;
    step();
    chk("R1 reset mid fill", pack_now(), IDLE_V);
    rst = 1'b0;
    step();
    step();
    chk("R2 no restart after reset", pack_now(), IDLE_V);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule